// File: doc/BRIEF.md
# Stereo-to-Dual-Mono Serial Audio Splitter

This block sits between a stereo serial audio source and two stereo DACs that each serve as a balanced mono converter. It receives one I2S-framed stream made of a bit clock, a word select and serial data. It rebuilds that stream as two output streams. The left output repeats the left sample in both word slots of its frame. The right output does the same with the right sample.

A wiring input selects the data for the second slot, the one with word select high. In straight wiring, where like DAC outputs are tied together, that slot carries the same bits as the first slot. In crossed wiring, where each slot's positive output is tied to the other slot's negative output, that slot carries the bitwise complement of the 24 data bits.

Each word is shifted in, held as a parallel value, and clocked out again one frame later. Both outputs share the pass-through bit clock and word select, so the two mono DACs stay in phase.

Top module: `dmono_split`

## Requirements
- R1: After the active-low synchronous reset `rst_n`, both data outputs stay low until a left word and then a right word have been captured. Output starts at the next falling transition of word select.
- R2: The input uses I2S framing. Word select low marks the left slot. The MSB is sampled on the rising bit-clock edge one bit clock after the word select transition, and the next WORD_W bits (default 24) are captured MSB first.
- R3: In every slot of a valid output frame, the left output carries the left word captured during the previous input frame, MSB first.
- R4: In every slot of a valid output frame, the right output carries the right word captured during the previous input frame, MSB first.
- R5: With `wiring_i` = 0 (straight), the slot with word select high carries the same bits as the slot with word select low.
- R6: With `wiring_i` = 1 (crossed), the slot with word select high carries the bitwise NOT of each data bit. This is not a two's-complement negation.
- R7: Bit positions WORD_W+1 through SLOT_W (default 25 to 32) of every output slot are 0 in both wiring modes.
- R8: Output data changes only on falling bit-clock edges. Output bit i of a slot is valid at the (i+1)-th rising edge after the word select transition, so the outputs trail the input by exactly one frame.
- R9: `wiring_i` is sampled only at the falling transition of word select. A change in the middle of a frame takes effect from the next frame's first slot.
- R10: `bclk_o` and `ws_o` follow `bclk_i` and `ws_i` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; input data sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_i | input | 1 | Word select: 0 for the left slot, 1 for the right slot |
| sd_i | input | 1 | Serial stereo data, MSB first |
| wiring_i | input | 1 | 0 for straight DAC wiring, 1 for crossed wiring |
| bclk_o | output | 1 | Pass-through bit clock for both DACs |
| ws_o | output | 1 | Pass-through word select for both DACs |
| sd_left_o | output | 1 | Left sample repeated in both slots |
| sd_right_o | output | 1 | Right sample repeated in both slots |

## Verification
The bench builds the block with WORD_W = 8 and SLOT_W = 12. A frame is then only 24 bit clocks long, so all 256 left-word values pass through within 300 frames. Every output bit of every slot is compared with a value computed from the driven words. With four padding bits per slot, the zero fill is checked in both wiring modes. The short frames also allow many wiring changes, both at frame starts and in the middle of frames, which exercises the boundary sampling of the wiring input and the difference between bitwise NOT and negation for every word value.

// File: rtl/dmono_pkg.sv
package dmono_pkg;
   typedef enum logic {
      WIRING_STRAIGHT = 1'b0,
      WIRING_CROSSED  = 1'b1
   } wiring_e;

   typedef enum logic {
      SLOT_WS_LO = 1'b0,
      SLOT_WS_HI = 1'b1
   } slot_e;
endpackage

// File: rtl/dmono_frame_trk.sv
module dmono_frame_trk #(
   parameter int SLOT_W = 32,
   localparam int CW = $clog2(SLOT_W)
) (
   input  logic          bclk,
   input  logic          rst_n,
   input  logic          ws,
   output logic [CW-1:0] cnt,
   output logic          slot,
   output logic          synced,
   output logic          ws_fall
);
   localparam logic [CW-1:0] CMAX = CW'(SLOT_W - 1);

   logic ws_q;
   logic ws_edge;

   assign ws_edge = ws ^ ws_q;
   assign ws_fall = ws_q & ~ws;

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         ws_q   <= 1'b0;
         cnt    <= CMAX;
         slot   <= 1'b0;
         synced <= 1'b0;
      end else begin
         ws_q <= ws;
         if (ws_edge) begin
            cnt    <= '0;
            slot   <= ws;
            synced <= 1'b1;
         end else if (cnt != CMAX) begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   AST_SLOT_TRACKS_WS: assert property (@(posedge bclk) disable iff (!rst_n)
      (synced && !ws_edge) |-> (slot == ws)); // R2
endmodule

// File: rtl/dmono_capture.sv
module dmono_capture #(
   parameter int WORD_W = 24,
   parameter int SLOT_W = 32,
   localparam int CW = $clog2(SLOT_W)
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              sd,
   input  logic [CW-1:0]     cnt,
   input  logic              slot,
   input  logic              synced,
   output logic [WORD_W-1:0] word_l,
   output logic [WORD_W-1:0] word_r,
   output logic              have_l,
   output logic              have_r
);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] next_word;
   logic              in_word;
   logic              done;
   logic [1:0]        cap_stb;
   logic [WORD_W-1:0] held [2];
   logic [1:0]        have;

   assign in_word   = synced && (cnt <= LAST);
   assign done      = synced && (cnt == LAST);
   assign next_word = {shreg[WORD_W-2:0], sd};

   always_ff @(posedge bclk) begin
      if (!rst_n) shreg <= '0;
      else if (in_word) shreg <= next_word;
   end

   for (genvar c = 0; c < 2; c++) begin : g_chan
      assign cap_stb[c] = done && (slot == (c == 1));
      always_ff @(posedge bclk) begin
         if (!rst_n) begin
            held[c] <= '0;
         end else if (cap_stb[c]) begin
            held[c] <= next_word;
         end
      end
   end

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         have <= 2'b00;
      end else begin
         if (cap_stb[0]) have[0] <= 1'b1;
         if (cap_stb[1] && have[0]) have[1] <= 1'b1;
      end
   end

   assign word_l = held[0];
   assign word_r = held[1];
   assign have_l = have[0];
   assign have_r = have[1];

   AST_ONE_CAPTURE: assert property (@(posedge bclk) disable iff (!rst_n)
      $onehot0(cap_stb)); // R2
   AST_RIGHT_AFTER_LEFT: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(have_r) |-> have_l); // R1
endmodule

// File: rtl/dmono_slot_ser.sv
module dmono_slot_ser #(
   parameter int WORD_W   = 24,
   parameter int SLOT_W   = 32,
   parameter bit INV_SLOT = 1'b1,
   localparam int CW = $clog2(SLOT_W)
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              inv,
   input  logic [WORD_W-1:0] word,
   input  logic [CW-1:0]     cnt,
   input  logic              slot,
   output logic              sd
);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [CW-1:0]     idx;
   logic [WORD_W-1:0] shifted;
   logic              bit_true;
   logic              bit_inv;
   logic              pick_inv;
   logic              bit_sel;

   assign idx      = LAST - cnt;
   assign shifted  = word >> idx;
   assign bit_true = shifted[0];
   assign bit_inv  = ~bit_true;

   if (INV_SLOT) begin : g_inv_hi
      assign pick_inv = inv && slot;
   end else begin : g_inv_lo
      assign pick_inv = inv && !slot;
   end

   assign bit_sel = pick_inv ? bit_inv : bit_true;

   always_ff @(negedge bclk) begin
      if (!rst_n) sd <= 1'b0;
      else if (!valid || (cnt > LAST)) sd <= 1'b0;
      else sd <= bit_sel;
   end

   AST_PAD_ZERO: assert property (@(negedge bclk) disable iff (!rst_n)
      $past(cnt > LAST) |-> (sd == 1'b0)); // R7
   AST_QUIET_BEFORE_VALID: assert property (@(negedge bclk) disable iff (!rst_n)
      $past(!valid) |-> (sd == 1'b0)); // R1
endmodule

// File: rtl/dmono_split.sv
module dmono_split #(
   parameter int WORD_W   = 24,
   parameter int SLOT_W   = 32,
   parameter bit INV_SLOT = 1'b1
) (
   input  logic bclk_i,
   input  logic rst_n,
   input  logic ws_i,
   input  logic sd_i,
   input  logic wiring_i,
   output logic bclk_o,
   output logic ws_o,
   output logic sd_left_o,
   output logic sd_right_o
);
   import dmono_pkg::*;

   localparam int CW = $clog2(SLOT_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("dmono_split: WORD_W must be at least 2");
   end
   if (WORD_W > SLOT_W) begin : g_bad_slot
      $error("dmono_split: WORD_W must not exceed SLOT_W");
   end

   logic [CW-1:0]     cnt;
   logic              slot;
   logic              synced;
   logic              ws_fall;
   logic [WORD_W-1:0] word_l;
   logic [WORD_W-1:0] word_r;
   logic              have_l;
   logic              have_r;
   logic [WORD_W-1:0] rep [2];
   logic [1:0]        sd_out;
   wiring_e           wiring_q;
   logic              valid;

   dmono_frame_trk #(.SLOT_W(SLOT_W)) u_trk (
      .bclk(bclk_i), .rst_n(rst_n), .ws(ws_i),
      .cnt(cnt), .slot(slot), .synced(synced), .ws_fall(ws_fall)
   );

   dmono_capture #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_cap (
      .bclk(bclk_i), .rst_n(rst_n), .sd(sd_i), .cnt(cnt), .slot(slot),
      .synced(synced), .word_l(word_l), .word_r(word_r),
      .have_l(have_l), .have_r(have_r)
   );

   always_ff @(posedge bclk_i) begin
      if (!rst_n) begin
         rep[0]   <= '0;
         rep[1]   <= '0;
         wiring_q <= WIRING_STRAIGHT;
         valid    <= 1'b0;
      end else if (ws_fall) begin
         rep[0]   <= word_l;
         rep[1]   <= word_r;
         wiring_q <= wiring_e'(wiring_i);
         if (have_r) valid <= 1'b1;
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_out
      dmono_slot_ser #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .INV_SLOT(INV_SLOT)) u_ser (
         .bclk(bclk_i), .rst_n(rst_n), .valid(valid),
         .inv(wiring_q == WIRING_CROSSED), .word(rep[c]),
         .cnt(cnt), .slot(slot), .sd(sd_out[c])
      );
   end

   assign bclk_o     = bclk_i;
   assign ws_o       = ws_i;
   assign sd_left_o  = sd_out[0];
   assign sd_right_o = sd_out[1];

   AST_WIRING_AT_BOUNDARY: assert property (@(posedge bclk_i) disable iff (!rst_n)
      !$stable(wiring_q) |-> $past(ws_fall)); // R9
   AST_VALID_STICKY: assert property (@(posedge bclk_i) disable iff (!rst_n)
      !$fell(valid)); // R1
   AST_REPLAY_AT_BOUNDARY: assert property (@(posedge bclk_i) disable iff (!rst_n)
      !$stable(rep[0]) |-> $past(ws_fall)); // R8
endmodule

// File: tb/sim_dmono_split.sv
module sim_dmono_split;
   localparam int CLK_PERIOD = 20;
   localparam int W  = 8;
   localparam int S  = 12;
   localparam int F  = 2 * S;
   localparam int NF = 300;

   logic bclk = 1'b0;
   logic rst_n = 1'b0;
   logic ws = 1'b0;
   logic sd = 1'b0;
   logic wiring = 1'b0;
   logic bclk_o, ws_o, sd_l, sd_r;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic msel [NF];

   dmono_split #(.WORD_W(W), .SLOT_W(S), .INV_SLOT(1'b1)) u0 (
      .bclk_i(bclk), .rst_n(rst_n), .ws_i(ws), .sd_i(sd), .wiring_i(wiring),
      .bclk_o(bclk_o), .ws_o(ws_o), .sd_left_o(sd_l), .sd_right_o(sd_r)
   );

   always #(CLK_PERIOD / 2) bclk = ~bclk;

   function automatic int lword(int f);
      return f % 256;
   endfunction

   function automatic int rword(int f);
      return (f * 37 + 11) % 256;
   endfunction

   function automatic logic base_mode(int f);
      return logic'((f / 3) % 2);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_for(int f, int p, bit left);
      int  i = p % S;
      bit  hi = (p >= S);
      string t;
      if (f < 2) return "R1 quiet before first full frame";
      if (i >= W) t = "R7 padding";
      else if (!hi) t = left ? "R3 left word" : "R4 right word";
      else if (msel[f-1]) t = "R6 crossed slot";
      else t = "R5 straight slot";
      if (((f - 1) % 5) == 0) t = {t, " R9 mid-frame wiring change"};
      return {t, " (R2 R8 framing and lag)"};
   endfunction

   function automatic logic exp_bit(int f, int p, bit left);
      int i = p % S;
      bit hi = (p >= S);
      int w;
      if (f < 2 || i >= W) return 1'b0;
      w = left ? lword(f - 1) : rword(f - 1);
      return logic'(((w >> (W - 1 - i)) & 1) ^ (hi & msel[f-1]));
   endfunction

   initial begin
      for (int f = 0; f < NF; f++) begin
         for (int p = 0; p < F; p++) begin
            @(negedge bclk);
            #1;
            if (f == 0 && p == 3) rst_n = 1'b1;
            ws = ((p >= S - 1) && (p < F - 1)) ? 1'b1 : 1'b0;
            if (p < S) sd = (p < W) ? logic'((lword(f) >> (W - 1 - p)) & 1) : 1'b0;
            else sd = ((p - S) < W) ? logic'((rword(f) >> (W - 1 - (p - S))) & 1) : 1'b0;
            if (p == 0) wiring = base_mode(f);
            if (p == S / 2 && (f % 5) == 0) wiring = ~base_mode(f);
            if (p == F - 1) msel[f] = wiring;
            @(posedge bclk);
            #(CLK_PERIOD / 4);
            chk(tag_for(f, p, 1'b1), sd_l, exp_bit(f, p, 1'b1));
            chk(tag_for(f, p, 1'b0), sd_r, exp_bit(f, p, 1'b0));
            if (p == 0 || p == S - 1) begin
               chk("R10 word select pass-through", ws_o, ws);
               chk("R10 bit clock pass-through", bclk_o, 1'b1);
            end
         end
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired before the sweep ended");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule